// File: doc/BRIEF.md
# Domain-Based Slave Access Guard

This block decides, for every access a requester makes to a target slave, whether the access may proceed. It holds a 2-bit policy code for every pairing of requester domain and slave. A check port takes the requester's domain, the slave index, a secure flag and the read/write direction. It answers allow or deny in the same cycle, with no register in that path.

Software programs the policy table through an APB-style register port. The same port reaches a lock register, which freezes the policy of selected slaves in every domain, and a status register. The status register flags the first denied access and records which domain and slave caused it. Decoding bus addresses into slave indices, raising interrupts and the bus fabric itself belong to neighbouring blocks.

Top module: `apc_domain_guard`

## Requirements
- R1: After reset every policy field, the lock register and the status register read zero, and every in-range check is allowed.
- R2: The policy word for domain d and word index r is at byte offset d*0x40 + r*4. Slave s has its code in bits [2*(s%16)+1 : 2*(s%16)] of word s/16. A write takes effect at the end of its access phase, and a later read returns the stored word.
- R3: The codes mean the following. 0 allows everything. 1 allows only secure accesses. 2 allows secure accesses and non-secure reads. 3 denies everything. The allow output follows the check inputs combinationally.
- R4: Fields of slaves 59 and above are dropped on write and read as zero. A check aimed at slave 59 or above is denied.
- R5: Addresses of domains 16 and above, and every other unmapped or unaligned address, read as zero, and writes to them change nothing.
- R6: The lock register sits at offset 0x700. Writing 1 to bit s (s < 16) locks slave s in every domain, after which writes to that slave's field are dropped. Writing 0 leaves a lock bit unchanged, so only reset clears it.
- R7: The status register sits at offset 0xF00. The first denied check with chk_valid high sets bit 31 at the next clock edge. The same edge stores the slave index in bits [5:0] and the domain in bits [19:16].
- R8: While bit 31 is set, further denials change neither the flag nor the captured domain and slave.
- R9: Writing the status register with bit 31 set clears the flag and the captured fields. Writing it with bit 31 clear has no effect. If a clear and a denial fall in the same cycle, the new denial is captured.
- R10: A check with chk_valid low records nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the block |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| chk_valid | input | 1 | Check request is live |
| chk_domain | input | 4 | Requester domain |
| chk_slave | input | 6 | Target slave index |
| chk_secure | input | 1 | Request is secure |
| chk_write | input | 1 | 1 = write, 0 = read |
| chk_allow | output | 1 | Access may pass |

## Verification
The bench programs a word with all four codes side by side and tries secure and non-secure reads and writes on each. A wrong decode shows up as a flipped allow, most easily a non-secure read under code 2. It writes all ones into the last policy word and into the word and domain just past the table. A design that ignores the slave or domain bounds would read back the extra bits or alias them onto domain 0. It locks slaves 5 and 11, then writes them in two domains and tries to clear the lock. A design that applied the lock to one domain only, or allowed unlocking, would read back changed fields. It causes several denials in a row and writes the status register with bit 31 both clear and set. A design that overwrote the capture, or cleared on any write, would report the wrong slave or a missing flag.

// File: rtl/apc_pkg.sv
package apc_pkg;

    typedef enum logic [1:0] {
        PERM_OPEN     = 2'd0,
        PERM_SEC_ONLY = 2'd1,
        PERM_SEC_NSRD = 2'd2,
        PERM_BLOCK    = 2'd3
    } perm_code_e;

    localparam int FIELD_W       = 2;
    localparam int WORD_W        = 32;
    localparam int FIELDS_PER_WD = WORD_W / FIELD_W;
    localparam int DOM_STRIDE_LG = 6;
    localparam int LOCK_OFS      = 'h700;
    localparam int STAT_OFS      = 'hF00;
    localparam int FLAG_BIT      = 31;
    localparam int STAT_DOM_LSB  = 16;

endpackage

// File: rtl/apc_policy_table.sv
module apc_policy_table
    import apc_pkg::*;
#(
    parameter int NUM_DOMAINS = 16,
    parameter int NUM_SLAVES  = 59,
    localparam int DOM_W      = $clog2(NUM_DOMAINS),
    localparam int SLV_W      = $clog2(NUM_SLAVES),
    localparam int NUM_WORDS  = (NUM_SLAVES + FIELDS_PER_WD - 1) / FIELDS_PER_WD
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [DOM_W-1:0]         wr_dom,
    input  logic [3:0]               wr_word,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [FIELDS_PER_WD-1:0] lock_mask,
    input  logic [DOM_W-1:0]         rd_dom,
    input  logic [3:0]               rd_word,
    output logic [WORD_W-1:0]        rd_data,
    input  logic [DOM_W-1:0]         chk_dom,
    input  logic [SLV_W-1:0]         chk_slv,
    output perm_code_e               chk_code
);

    typedef struct packed {
        logic [NUM_DOMAINS-1:0][NUM_SLAVES-1:0][FIELD_W-1:0] perm;
    } table_t;

    table_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && int'(wr_word) < NUM_WORDS) begin
            for (int s = 0; s < NUM_SLAVES; s++) begin
                if ((s / FIELDS_PER_WD) == int'(wr_word)) begin
                    if (!((s < FIELDS_PER_WD) && lock_mask[s % FIELDS_PER_WD])) begin
                        tbl_d.perm[wr_dom][s] = wr_data[FIELD_W*(s % FIELDS_PER_WD) +: FIELD_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NUM_SLAVES; s++) begin
            if ((s / FIELDS_PER_WD) == int'(rd_word)) begin
                rd_data[FIELD_W*(s % FIELDS_PER_WD) +: FIELD_W] = tbl_q.perm[rd_dom][s];
            end
        end
    end

    always_comb begin
        if (int'(chk_slv) < NUM_SLAVES) chk_code = perm_code_e'(tbl_q.perm[chk_dom][chk_slv]);
        else                            chk_code = PERM_BLOCK;
    end

endmodule

// File: rtl/apc_access_judge.sv
module apc_access_judge
    import apc_pkg::*;
(
    input  perm_code_e code,
    input  logic       valid,
    input  logic       secure,
    input  logic       is_write,
    output logic       allow,
    output logic       deny_evt
);

    always_comb begin
        unique case (code)
            PERM_OPEN:     allow = 1'b1;
            PERM_SEC_ONLY: allow = secure;
            PERM_SEC_NSRD: allow = secure | ~is_write;
            default:       allow = 1'b0;
        endcase
        deny_evt = valid & ~allow;
    end

endmodule

// File: rtl/apc_ctrl_regs.sv
module apc_ctrl_regs
    import apc_pkg::*;
#(
    parameter int DOM_W = 4,
    parameter int SLV_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lock_wr,
    input  logic [FIELDS_PER_WD-1:0] lock_set,
    input  logic                     viol_clr,
    input  logic                     deny_evt,
    input  logic [DOM_W-1:0]         evt_dom,
    input  logic [SLV_W-1:0]         evt_slv,
    output logic [FIELDS_PER_WD-1:0] lock_bits,
    output logic                     viol_flag,
    output logic [WORD_W-1:0]        stat_word
);

    typedef struct packed {
        logic [FIELDS_PER_WD-1:0] lock;
        logic                     flag;
        logic [DOM_W-1:0]         dom;
        logic [SLV_W-1:0]         slv;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (lock_wr) ctl_d.lock = ctl_q.lock | lock_set;
        if (viol_clr) begin
            ctl_d.flag = 1'b0;
            ctl_d.dom  = '0;
            ctl_d.slv  = '0;
        end
        if (deny_evt && !ctl_d.flag) begin
            ctl_d.flag = 1'b1;
            ctl_d.dom  = evt_dom;
            ctl_d.slv  = evt_slv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        stat_word                           = '0;
        stat_word[FLAG_BIT]                 = ctl_q.flag;
        stat_word[STAT_DOM_LSB +: DOM_W]    = ctl_q.dom;
        stat_word[0 +: SLV_W]               = ctl_q.slv;
        lock_bits                           = ctl_q.lock;
        viol_flag                           = ctl_q.flag;
    end

endmodule

// File: rtl/apc_domain_guard.sv
module apc_domain_guard
    import apc_pkg::*;
#(
    parameter int NUM_DOMAINS = 16,
    parameter int NUM_SLAVES  = 59,
    parameter int ADDR_W      = 12,
    localparam int DOM_W      = $clog2(NUM_DOMAINS),
    localparam int SLV_W      = $clog2(NUM_SLAVES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic              chk_valid,
    input  logic [DOM_W-1:0]  chk_domain,
    input  logic [SLV_W-1:0]  chk_slave,
    input  logic              chk_secure,
    input  logic              chk_write,
    output logic              chk_allow
);

    logic                     aligned, pol_hit, lock_hit, stat_hit, wr_fire;
    logic                     viol_clr, deny_evt, viol_flag;
    logic [DOM_W-1:0]         acc_dom;
    logic [3:0]               acc_word;
    logic [WORD_W-1:0]        pol_rdata, stat_word;
    logic [FIELDS_PER_WD-1:0] lock_q;
    perm_code_e               chk_code;

    always_comb begin
        aligned  = (paddr[1:0] == 2'b00);
        pol_hit  = aligned && (int'(paddr[ADDR_W-1:DOM_STRIDE_LG]) < NUM_DOMAINS);
        lock_hit = aligned && (int'(paddr) == LOCK_OFS);
        stat_hit = aligned && (int'(paddr) == STAT_OFS);
        acc_dom  = paddr[DOM_STRIDE_LG +: DOM_W];
        acc_word = paddr[5:2];
        wr_fire  = psel && penable && pwrite;
        viol_clr = wr_fire && stat_hit && pwdata[FLAG_BIT];
        if (pol_hit)       prdata = pol_rdata;
        else if (lock_hit) prdata = {{(WORD_W-FIELDS_PER_WD){1'b0}}, lock_q};
        else if (stat_hit) prdata = stat_word;
        else               prdata = '0;
    end

    apc_policy_table #(
        .NUM_DOMAINS(NUM_DOMAINS),
        .NUM_SLAVES (NUM_SLAVES)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_fire && pol_hit),
        .wr_dom   (acc_dom),
        .wr_word  (acc_word),
        .wr_data  (pwdata),
        .lock_mask(lock_q),
        .rd_dom   (acc_dom),
        .rd_word  (acc_word),
        .rd_data  (pol_rdata),
        .chk_dom  (chk_domain),
        .chk_slv  (chk_slave),
        .chk_code (chk_code)
    );

    apc_access_judge u_judge (
        .code    (chk_code),
        .valid   (chk_valid),
        .secure  (chk_secure),
        .is_write(chk_write),
        .allow   (chk_allow),
        .deny_evt(deny_evt)
    );

    apc_ctrl_regs #(
        .DOM_W(DOM_W),
        .SLV_W(SLV_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_wr  (wr_fire && lock_hit),
        .lock_set (pwdata[FIELDS_PER_WD-1:0]),
        .viol_clr (viol_clr),
        .deny_evt (deny_evt),
        .evt_dom  (chk_domain),
        .evt_slv  (chk_slave),
        .lock_bits(lock_q),
        .viol_flag(viol_flag),
        .stat_word(stat_word)
    );

endmodule

// File: rtl/apc_guard_checker.sv
module apc_guard_checker #(
    parameter int NUM_DOMAINS = 16,
    parameter int NUM_SLAVES  = 59,
    parameter int ADDR_W      = 12,
    parameter int DOM_W       = 4,
    parameter int SLV_W       = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       prdata,
    input logic              chk_valid,
    input logic [SLV_W-1:0]  chk_slave,
    input logic              chk_secure,
    input logic              chk_write,
    input logic              chk_allow,
    input logic [1:0]        chk_code,
    input logic              deny_evt,
    input logic              viol_flag,
    input logic              viol_clr,
    input logic [15:0]       lock_q,
    input logic [31:0]       stat_word
);

    p_no_pass_when_forbidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && chk_allow |-> chk_code != 2'd3);

    p_ns_write_needs_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && chk_allow && !chk_secure && chk_write |-> chk_code == 2'd0);

    p_oob_slave_denied_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && int'(chk_slave) >= NUM_SLAVES |-> !chk_allow);

    p_oob_domain_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !pwrite && int'(paddr[ADDR_W-1:6]) >= NUM_DOMAINS && int'(paddr) < 'h700
        |-> prdata == 32'd0);

    p_lock_never_falls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lock_q & $past(lock_q)) == $past(lock_q));

    p_deny_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        deny_evt |=> viol_flag);

    p_capture_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag && !viol_clr |=> viol_flag && $stable(stat_word));

endmodule

bind apc_domain_guard apc_guard_checker #(
    .NUM_DOMAINS(NUM_DOMAINS),
    .NUM_SLAVES (NUM_SLAVES),
    .ADDR_W     (ADDR_W),
    .DOM_W      (DOM_W),
    .SLV_W      (SLV_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .prdata    (prdata),
    .chk_valid (chk_valid),
    .chk_slave (chk_slave),
    .chk_secure(chk_secure),
    .chk_write (chk_write),
    .chk_allow (chk_allow),
    .chk_code  (chk_code),
    .deny_evt  (deny_evt),
    .viol_flag (viol_flag),
    .viol_clr  (viol_clr),
    .lock_q    (lock_q),
    .stat_word (stat_word)
);

// File: tb/tb_apc_domain_guard.sv
module tb_apc_domain_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        chk_valid = 1'b0, chk_secure = 1'b0, chk_write = 1'b0;
    logic [3:0]  chk_domain = '0;
    logic [5:0]  chk_slave = '0;
    logic        chk_allow;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd_exp_q[$];
    string       rd_tag_q[$];
    logic        ok_exp_q[$];
    string       ok_tag_q[$];

    always #2 clk = ~clk;

    apc_domain_guard dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .chk_valid(chk_valid),
        .chk_domain(chk_domain), .chk_slave(chk_slave), .chk_secure(chk_secure),
        .chk_write(chk_write), .chk_allow(chk_allow)
    );

    // Monitor: compares results away from the active edge
    always @(negedge clk) begin
        if (psel && penable && !pwrite && rd_exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = rd_exp_q.pop_front();
            t = rd_tag_q.pop_front();
            checks++;
            if (prdata !== e) begin
                errors++;
                $display("FAIL %s read actual=%h expected=%h", t, prdata, e);
            end
        end
        if (chk_valid && ok_exp_q.size() > 0) begin
            logic e;
            string t;
            e = ok_exp_q.pop_front();
            t = ok_tag_q.pop_front();
            checks++;
            if (chk_allow !== e) begin
                errors++;
                $display("FAIL %s allow actual=%b expected=%b", t, chk_allow, e);
            end
        end
    end

    task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic reg_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        rd_exp_q.push_back(e);
        rd_tag_q.push_back(tag);
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic chk(input logic [3:0] d, input logic [5:0] s, input logic sec,
                       input logic wr, input logic e, input string tag);
        @(posedge clk); #1;
        chk_valid = 1'b1; chk_domain = d; chk_slave = s; chk_secure = sec; chk_write = wr;
        ok_exp_q.push_back(e);
        ok_tag_q.push_back(tag);
        @(posedge clk); #1;
        chk_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        reg_rd(12'hF00, 32'h0, "R1 status");
        reg_rd(12'h700, 32'h0, "R1 lock");
        reg_rd(12'h3C0, 32'h0, "R1 policy d15 w0");
        chk(4'd15, 6'd58, 1'b0, 1'b1, 1'b1, "R1 open after reset");

        // R2 / R3: codes 0,1,2,3 on slaves 16..19 of domain 3
        reg_wr(12'h0C4, 32'hE4E4_E4E4);
        reg_rd(12'h0C4, 32'hE4E4_E4E4, "R2 readback d3 w1");
        chk(4'd3, 6'd16, 1'b0, 1'b1, 1'b1, "R3 code0 ns write");
        chk(4'd3, 6'd17, 1'b0, 1'b0, 1'b0, "R3 code1 ns read");
        chk(4'd3, 6'd17, 1'b1, 1'b1, 1'b1, "R3 code1 sec write");
        chk(4'd3, 6'd18, 1'b0, 1'b0, 1'b1, "R3 code2 ns read");
        chk(4'd3, 6'd18, 1'b0, 1'b1, 1'b0, "R3 code2 ns write");
        chk(4'd3, 6'd18, 1'b1, 1'b1, 1'b1, "R3 code2 sec write");
        chk(4'd3, 6'd19, 1'b1, 1'b0, 1'b0, "R3 code3 sec read");
        // R7 capture of first denial (dom 3, slave 17); R8 later denials ignored
        reg_rd(12'hF00, 32'h8003_0011, "R7 R8 status capture");

        // R9: write with bit 31 clear does nothing, set clears
        reg_wr(12'hF00, 32'h7FFF_FFFF);
        reg_rd(12'hF00, 32'h8003_0011, "R9 no clear without bit31");
        reg_wr(12'hF00, 32'h8000_0000);
        reg_rd(12'hF00, 32'h0, "R9 cleared");

        // R10: denied pattern without valid
        @(posedge clk); #1;
        chk_domain = 4'd3; chk_slave = 6'd19; chk_secure = 1'b0; chk_write = 1'b1;
        @(posedge clk); #1;
        reg_rd(12'hF00, 32'h0, "R10 no capture without valid");

        // R4: slaves beyond 58
        reg_wr(12'h00C, 32'hFFFF_FFFF);
        reg_rd(12'h00C, 32'h003F_FFFF, "R4 fields past last slave dropped");
        reg_wr(12'h010, 32'hFFFF_FFFF);
        reg_rd(12'h010, 32'h0, "R4 word past table");
        chk(4'd0, 6'd60, 1'b1, 1'b0, 1'b0, "R4 check beyond table denied");
        chk(4'd0, 6'd58, 1'b1, 1'b0, 1'b0, "R4 last slave code3");
        reg_rd(12'hF00, 32'h8000_003C, "R4 R8 capture slave 60");
        reg_wr(12'hF00, 32'h8000_0000);

        // R5: domain 16 and above, unaligned
        reg_wr(12'h400, 32'hFFFF_FFFF);
        reg_rd(12'h400, 32'h0, "R5 domain 16 reads zero");
        reg_rd(12'h000, 32'h0, "R5 no alias onto domain 0");
        reg_rd(12'h0C6, 32'h0, "R5 unaligned reads zero");

        // R6: lock slaves 5 and 11
        reg_wr(12'h700, 32'h0000_0820);
        reg_rd(12'h700, 32'h0000_0820, "R6 lock readback");
        reg_wr(12'h1C0, 32'hFFFF_FFFF);
        reg_rd(12'h1C0, 32'hFF3F_F3FF, "R6 locked fields kept in d7");
        reg_wr(12'h080, 32'h0000_0C00);
        reg_rd(12'h080, 32'h0, "R6 locked field kept in d2");
        reg_wr(12'h1C4, 32'hFFFF_FFFF);
        reg_rd(12'h1C4, 32'hFFFF_FFFF, "R6 unlocked word writable");
        chk(4'd7, 6'd5, 1'b0, 1'b1, 1'b1, "R6 locked slave stays open");
        reg_wr(12'h700, 32'h0);
        reg_rd(12'h700, 32'h0000_0820, "R6 lock not cleared by write");

        repeat (4) @(posedge clk);
        if (rd_exp_q.size() != 0 || ok_exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left items actual=%0d expected=0",
                     rd_exp_q.size() + ok_exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule